// File: doc/BRIEF.md
# Match-Channel System Timer with Watchdog

This block is a free-running 32-bit system timer with compare channels, reached over a small synchronous register bus. The count moves forward only on cycles where a slow-rate tick enable is high. That enable is a one-cycle strobe at 3.6864 MHz, produced outside the block from the faster core clock. The block has four compare registers. When the count steps onto a value held in compare register n, status bit n latches. That latched bit, gated by its enable bit, drives interrupt line n.

The last channel doubles as a watchdog. A small state machine sets this up. It has three states: `WD_OFF`, `WD_ARMED` and `WD_TRIPPED`.
- The transition ARM (`WD_OFF` to `WD_ARMED`) fires on a write of one to the watchdog enable bit.
- The transition TRIP (`WD_ARMED` to `WD_TRIPPED`) fires on a channel-3 match.
- In `WD_TRIPPED`, the transition HOLD keeps the state there until reset.
- Every other case stays in the current state.

While the machine is in `WD_TRIPPED`, the reset request output is high. Software can set the watchdog enable but can never clear it.

The bus uses word offsets, decoded as follows:
- Offsets 0 to 3: compare registers 0 to 3.
- Offset 4: counter.
- Offset 5: status, bits [3:0].
- Offset 6: watchdog enable, bit 0.
- Offset 7: interrupt enable, bits [3:0].
- Offsets 8 to 15: unmapped.

Top module: `os_match_timer`

## Requirements
- R1: After reset, the counter, all compare registers, status, interrupt enable and watchdog enable read as zero, and every irq line and the reset request are low.
- R2: The counter goes up by one at each clock edge where tick_i is high and holds at edges where it is low. It wraps from 0xFFFFFFFF to 0.
- R3: A bus write to the counter (offset 4) loads the written value even when tick_i is high in the same cycle. The write takes priority over the increment.
- R4: The compare registers (offsets 0 to 3) and the counter (offset 4) are readable and writable as full 32-bit values. Read data appears on bus_rdata_o after the clock edge that takes the read, and holds until the next read.
- R5: Status bit n sets at the edge where a tick moves the counter onto a value equal to compare register n. Loading the counter through the bus never sets a status bit.
- R6: Writing offset 5 clears each status bit whose written bit is one and leaves bits written with zero unchanged. If a match and a clear of the same bit fall in one cycle, the bit ends up set.
- R7: irq_o[n] is high exactly when status bit n and interrupt enable bit n (offset 7, bits [3:0]) are both set. Bits above 3 of offset 7 read zero and ignore writes.
- R8: A write to offset 6 with bit 0 set arms the watchdog. Writing zero there has no effect, and only reset disarms it. Offset 6 bit 0 reads the armed state.
- R9: With the watchdog armed, a channel-3 match raises reset_req_o at the same edge as status bit 3. The request stays high until reset. With the watchdog off, a channel-3 match leaves reset_req_o low.
- R10: Offsets 8 to 15 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle count enable at the timer rate |
| bus_en_i | input | 1 | Bus access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Word offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_o | output | 4 | Per-channel interrupt lines |
| reset_req_o | output | 1 | Watchdog reset request |

## Verification
Every result of this block lands one clock edge after the cycle that causes it:
- the loaded or incremented count;
- a latched status bit and the irq line gated from it;
- the tripped reset request;
- the registered read data.

The bench drives each stimulus half a cycle before the rising edge and advances its reference model across that same edge. It compares the irq lines, the reset request and any requested read data at the following falling edge. A read therefore returns register contents as they were before the edge that also applies that cycle's tick, clear or match.

// File: rtl/stm_pkg.sv
package stm_pkg;

    // Watchdog sequencing states
    typedef enum logic [1:0] {
        WD_OFF     = 2'd0,
        WD_ARMED   = 2'd1,
        WD_TRIPPED = 2'd2
    } wd_state_e;

    // Register offsets derived from the number of compare channels
    function automatic int unsigned off_count(input int unsigned nch);
        return nch;
    endfunction

    function automatic int unsigned off_status(input int unsigned nch);
        return nch + 1;
    endfunction

    function automatic int unsigned off_wden(input int unsigned nch);
        return nch + 2;
    endfunction

    function automatic int unsigned off_ien(input int unsigned nch);
        return nch + 3;
    endfunction

endpackage

// File: rtl/stm_counter.sv
module stm_counter #(
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_val_i,
    output logic [DATA_W-1:0] count_o,
    output logic              step_o,
    output logic [DATA_W-1:0] next_o
);

    localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

    logic [DATA_W-1:0] cnt_q;

    // A bus load suppresses the tick step in the same cycle
    assign step_o  = tick_i & ~load_i;
    assign next_o  = cnt_q + ONE;
    assign count_o = cnt_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (tick_i) begin
            cnt_q <= next_o;
        end
    end

    AST_CNT_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> count_o == $past(load_val_i)); // R3
    AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !load_i) |=> count_o == $past(count_o) + ONE); // R2
    AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !load_i) |=> $stable(count_o)); // R2

endmodule

// File: rtl/stm_match_bank.sv
module stm_match_bank #(
    parameter int DATA_W = 32,
    parameter int NUM_CH = 4
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic                           step_i,
    input  logic [DATA_W-1:0]              next_i,
    input  logic [NUM_CH-1:0]              wr_match_i,
    input  logic                           wr_status_i,
    input  logic                           wr_ien_i,
    input  logic [DATA_W-1:0]              wdata_i,
    output logic [NUM_CH-1:0][DATA_W-1:0]  match_o,
    output logic [NUM_CH-1:0]              status_o,
    output logic [NUM_CH-1:0]              ien_o,
    output logic [NUM_CH-1:0]              hit_o,
    output logic [NUM_CH-1:0]              irq_o
);

    logic [NUM_CH-1:0][DATA_W-1:0] match_q;
    logic [NUM_CH-1:0]             status_q;
    logic [NUM_CH-1:0]             ien_q;
    logic [NUM_CH-1:0]             clr_mask;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                match_q[g] <= '0;
            end else if (wr_match_i[g]) begin
                match_q[g] <= wdata_i;
            end
        end

        // Compare against the value the counter is stepping onto
        assign hit_o[g] = step_i && (next_i == match_q[g]);

        AST_MATCH_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
            hit_o[g] |=> status_o[g]); // R5
        AST_STAT_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (status_o[g] && !(wr_status_i && wdata_i[g])) |=> status_o[g]); // R6
        AST_STAT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (wr_status_i && wdata_i[g] && !hit_o[g]) |=> !status_o[g]); // R6
    end

    assign clr_mask = wr_status_i ? wdata_i[NUM_CH-1:0] : '0;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            status_q <= '0;
            ien_q    <= '0;
        end else begin
            status_q <= (status_q & ~clr_mask) | hit_o;
            if (wr_ien_i) begin
                ien_q <= wdata_i[NUM_CH-1:0];
            end
        end
    end

    assign match_o  = match_q;
    assign status_o = status_q;
    assign ien_o    = ien_q;
    assign irq_o    = status_q & ien_q;

endmodule

// File: rtl/stm_wdog.sv
module stm_wdog
    import stm_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic arm_i,
    input  logic trig_i,
    output logic armed_o,
    output logic reset_req_o
);

    wd_state_e st_q, st_d;

    // State register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= WD_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    // Transitions: ARM, TRIP, HOLD
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            WD_OFF:     if (arm_i)  st_d = WD_ARMED;
            WD_ARMED:   if (trig_i) st_d = WD_TRIPPED;
            WD_TRIPPED: st_d = WD_TRIPPED;
            default:    st_d = WD_OFF;
        endcase
    end

    // Outputs
    always_comb begin
        armed_o     = (st_q != WD_OFF);
        reset_req_o = (st_q == WD_TRIPPED);
    end

    AST_WD_NO_DISARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        armed_o |=> armed_o); // R8
    AST_WD_REQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reset_req_o |=> reset_req_o); // R9
    AST_WD_REQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(reset_req_o) |-> ($past(armed_o) && $past(trig_i))); // R9

endmodule

// File: rtl/stm_regif.sv
module stm_regif
    import stm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 4
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic                           bus_en_i,
    input  logic                           bus_we_i,
    input  logic [ADDR_W-1:0]              bus_addr_i,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  match_i,
    input  logic [DATA_W-1:0]              count_i,
    input  logic [NUM_CH-1:0]              status_i,
    input  logic [NUM_CH-1:0]              ien_i,
    input  logic                           armed_i,
    output logic [NUM_CH-1:0]              wr_match_o,
    output logic                           wr_count_o,
    output logic                           wr_status_o,
    output logic                           wr_wden_o,
    output logic                           wr_ien_o,
    output logic [DATA_W-1:0]              rdata_o
);

    localparam logic [ADDR_W-1:0] OFF_CNT  = ADDR_W'(off_count(NUM_CH));
    localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(off_status(NUM_CH));
    localparam logic [ADDR_W-1:0] OFF_WDEN = ADDR_W'(off_wden(NUM_CH));
    localparam logic [ADDR_W-1:0] OFF_IEN  = ADDR_W'(off_ien(NUM_CH));

    logic              wr_any;
    logic              rd_any;
    logic [DATA_W-1:0] rd_val;
    logic [DATA_W-1:0] rdata_q;

    assign wr_any = bus_en_i &  bus_we_i;
    assign rd_any = bus_en_i & ~bus_we_i;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_wsel
        assign wr_match_o[g] = wr_any && (bus_addr_i == ADDR_W'(g));
    end

    assign wr_count_o  = wr_any && (bus_addr_i == OFF_CNT);
    assign wr_status_o = wr_any && (bus_addr_i == OFF_STAT);
    assign wr_wden_o   = wr_any && (bus_addr_i == OFF_WDEN);
    assign wr_ien_o    = wr_any && (bus_addr_i == OFF_IEN);

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr_i == ADDR_W'(i)) rd_val = match_i[i];
        end
        if (bus_addr_i == OFF_CNT)  rd_val = count_i;
        if (bus_addr_i == OFF_STAT) rd_val = DATA_W'(status_i);
        if (bus_addr_i == OFF_WDEN) rd_val = DATA_W'(armed_i);
        if (bus_addr_i == OFF_IEN)  rd_val = DATA_W'(ien_i);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rdata_q <= '0;
        end else if (rd_any) begin
            rdata_q <= rd_val;
        end
    end

    assign rdata_o = rdata_q;

    AST_RD_UNMAPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_any && (bus_addr_i > OFF_IEN)) |=> rdata_o == '0); // R10
    AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_any |=> $stable(rdata_o)); // R4

endmodule

// File: rtl/os_match_timer.sv
module os_match_timer #(
    parameter int DATA_W = 32,
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              bus_en_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic [NUM_CH-1:0] irq_o,
    output logic              reset_req_o
);

    localparam int WD_CH = NUM_CH - 1;

    logic [NUM_CH-1:0][DATA_W-1:0] match_w;
    logic [DATA_W-1:0]             count_w;
    logic [DATA_W-1:0]             next_w;
    logic                          step_w;
    logic [NUM_CH-1:0]             status_w;
    logic [NUM_CH-1:0]             ien_w;
    logic [NUM_CH-1:0]             hit_w;
    logic [NUM_CH-1:0]             wr_match_w;
    logic                          wr_count_w;
    logic                          wr_status_w;
    logic                          wr_wden_w;
    logic                          wr_ien_w;
    logic                          armed_w;

    stm_regif #(
        .DATA_W (DATA_W),
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_regif (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .bus_en_i    (bus_en_i),
        .bus_we_i    (bus_we_i),
        .bus_addr_i  (bus_addr_i),
        .match_i     (match_w),
        .count_i     (count_w),
        .status_i    (status_w),
        .ien_i       (ien_w),
        .armed_i     (armed_w),
        .wr_match_o  (wr_match_w),
        .wr_count_o  (wr_count_w),
        .wr_status_o (wr_status_w),
        .wr_wden_o   (wr_wden_w),
        .wr_ien_o    (wr_ien_w),
        .rdata_o     (bus_rdata_o)
    );

    stm_counter #(
        .DATA_W (DATA_W)
    ) u_counter (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (tick_i),
        .load_i     (wr_count_w),
        .load_val_i (bus_wdata_i),
        .count_o    (count_w),
        .step_o     (step_w),
        .next_o     (next_w)
    );

    stm_match_bank #(
        .DATA_W (DATA_W),
        .NUM_CH (NUM_CH)
    ) u_bank (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .step_i      (step_w),
        .next_i      (next_w),
        .wr_match_i  (wr_match_w),
        .wr_status_i (wr_status_w),
        .wr_ien_i    (wr_ien_w),
        .wdata_i     (bus_wdata_i),
        .match_o     (match_w),
        .status_o    (status_w),
        .ien_o       (ien_w),
        .hit_o       (hit_w),
        .irq_o       (irq_o)
    );

    stm_wdog u_wdog (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .arm_i       (wr_wden_w && bus_wdata_i[0]),
        .trig_i      (hit_w[WD_CH]),
        .armed_o     (armed_w),
        .reset_req_o (reset_req_o)
    );

    AST_REQ_WITH_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(reset_req_o) |-> status_w[WD_CH]); // R9
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_ien_w && (bus_wdata_i[NUM_CH-1:0] == '0)) |=> (irq_o == '0)); // R7

endmodule

// File: tb/os_match_timer_bench.sv
module os_match_timer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYC   = 200000;

    logic        clk;
    logic        rst_n;
    logic        tick;
    logic        en;
    logic        we;
    logic [3:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [3:0]  irq;
    logic        rreq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // reference model
    logic [31:0] m_cnt;
    logic [31:0] m_match [4];
    logic [3:0]  m_stat;
    logic [3:0]  m_ien;
    logic        m_wd;
    logic        m_rst;

    os_match_timer u_os_match_timer (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .tick_i      (tick),
        .bus_en_i    (en),
        .bus_we_i    (we),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq),
        .reset_req_o (rreq)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [31:0] model_read(input logic [3:0] a);
        case (a)
            4'd0, 4'd1, 4'd2, 4'd3: return m_match[a[1:0]];
            4'd4: return m_cnt;
            4'd5: return {28'd0, m_stat};
            4'd6: return {31'd0, m_wd};
            4'd7: return {28'd0, m_ien};
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cnt = 32'd0;
        for (int i = 0; i < 4; i++) m_match[i] = 32'd0;
        m_stat = 4'd0;
        m_ien  = 4'd0;
        m_wd   = 1'b0;
        m_rst  = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        en = 1'b0; we = 1'b0; addr = 4'd0; wdata = 32'd0; tick = 1'b0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One bus cycle, called at a falling edge; checks at the next falling edge.
    task automatic cycle(input logic e, input logic w, input logic [3:0] a,
                         input logic [31:0] d, input logic tk, input string tag);
        logic [31:0] exp_rd;
        logic        wr_c;
        logic        step;
        logic [31:0] nxt;
        logic [3:0]  hits;
        logic [3:0]  clr;
        logic        wd_old;
        en = e; we = w; addr = a; wdata = d; tick = tk;
        exp_rd = model_read(a);
        wr_c   = e && w && (a == 4'd4);
        step   = tk && !wr_c;
        nxt    = m_cnt + 32'd1;
        for (int i = 0; i < 4; i++) hits[i] = step && (nxt == m_match[i]);
        clr    = (e && w && a == 4'd5) ? d[3:0] : 4'd0;
        wd_old = m_wd;
        @(posedge clk);
        @(negedge clk);
        if (wr_c) m_cnt = d;
        else if (tk) m_cnt = nxt;
        if (e && w && a < 4'd4) m_match[a[1:0]] = d;
        m_stat = (m_stat & ~clr) | hits;
        if (e && w && a == 4'd7) m_ien = d[3:0];
        if (e && w && a == 4'd6 && d[0]) m_wd = 1'b1;
        if (wd_old && hits[3]) m_rst = 1'b1;
        en = 1'b0; we = 1'b0; tick = 1'b0;
        if (e && !w) chk(tag, rdata, exp_rd);
        chk("R7 irq", {28'd0, irq}, {28'd0, m_stat & m_ien});
        chk("R9 reset_req", {31'd0, rreq}, {31'd0, m_rst});
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        cycle(1'b1, 1'b1, a, d, 1'b0, "write");
    endtask

    task automatic rd(input logic [3:0] a, input string tag);
        cycle(1'b1, 1'b0, a, 32'd0, 1'b0, tag);
    endtask

    task automatic idle(input logic tk);
        cycle(1'b0, 1'b0, 4'd0, 32'd0, tk, "idle");
    endtask

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20241));
        do_reset();

        // R1: reset state
        chk("R1 irq", {28'd0, irq}, 32'd0);
        chk("R1 reset_req", {31'd0, rreq}, 32'd0);
        for (int a = 0; a < 8; a++) rd(4'(a), "R1");

        // R4: full-width register access
        wr(4'd0, 32'h0000_0100);
        wr(4'd1, 32'h0000_0200);
        wr(4'd2, 32'h0000_0300);
        wr(4'd3, 32'h0000_0400);
        wr(4'd4, 32'hA5C3_0F12);
        for (int a = 0; a < 5; a++) rd(4'(a), "R4");

        // R2: wrap and hold
        wr(4'd4, 32'hFFFF_FFFE);
        idle(1'b1);
        idle(1'b1);
        rd(4'd4, "R2 wrap");
        idle(1'b0);
        idle(1'b0);
        rd(4'd4, "R2 hold");

        // R3: load beats tick
        cycle(1'b1, 1'b1, 4'd4, 32'h0000_0050, 1'b1, "R3");
        rd(4'd4, "R3");

        // R5: load onto a compare value does not match; tick does
        wr(4'd4, 32'h0000_0200);
        rd(4'd5, "R5 load no match");
        wr(4'd4, 32'h0000_02FF);
        idle(1'b1);
        rd(4'd5, "R5 tick match");

        // R7: interrupt enable reserved bits
        wr(4'd7, 32'hFFFF_FFF4);
        rd(4'd7, "R7 reserved");
        chk("R7 irq2", {28'd0, irq}, 32'h4);

        // R6: write-one-to-clear
        wr(4'd5, 32'd0);
        rd(4'd5, "R6 zero keeps");
        wr(4'd5, 32'h4);
        rd(4'd5, "R6 one clears");
        wr(4'd4, 32'h0000_02FF);
        cycle(1'b1, 1'b1, 4'd5, 32'h4, 1'b1, "R6 set wins");
        rd(4'd5, "R6 set wins");

        // R10: unmapped offsets
        rd(4'd8, "R10");
        rd(4'd15, "R10");
        wr(4'd9, 32'hFFFF_FFFF);
        wr(4'd14, 32'hFFFF_FFFF);
        for (int a = 0; a < 8; a++) rd(4'(a), "R10 unchanged");

        // R8: set-only enable
        wr(4'd6, 32'd0);
        rd(4'd6, "R8 zero");
        wr(4'd6, 32'd1);
        rd(4'd6, "R8 armed");
        wr(4'd6, 32'd0);
        rd(4'd6, "R8 no disarm");

        // R9: trip and hold
        wr(4'd4, 32'h0000_03FF);
        idle(1'b1);
        chk("R9 trip", {31'd0, rreq}, 32'd1);
        idle(1'b1);
        idle(1'b1);
        chk("R9 held", {31'd0, rreq}, 32'd1);

        // R9: no request while disarmed
        do_reset();
        wr(4'd3, 32'h0000_0010);
        wr(4'd4, 32'h0000_000F);
        idle(1'b1);
        chk("R9 disarmed", {31'd0, rreq}, 32'd0);
        rd(4'd5, "R9 status only");

        // Constrained random traffic
        do_reset();
        for (int k = 0; k < 4000; k++) begin
            int unsigned op;
            logic tk;
            op = $urandom % 8;
            tk = 1'($urandom % 2);
            case (op)
                0, 1, 2: idle(tk);
                3: cycle(1'b1, 1'b0, 4'($urandom % 16), 32'd0, tk, "R4 random read");
                4: cycle(1'b1, 1'b1, 4'($urandom % 4), $urandom % 64, tk, "wr");
                5: cycle(1'b1, 1'b1, 4'd4, $urandom % 64, tk, "wr");
                6: begin
                    if ($urandom % 16 == 0)
                        cycle(1'b1, 1'b1, 4'd6, $urandom, tk, "wr");
                    else
                        cycle(1'b1, 1'b1, 4'(5 + 2 * ($urandom % 2)), $urandom, tk, "wr");
                end
                default: cycle(1'b1, 1'b1, 4'(8 + $urandom % 8), $urandom, tk, "wr");
            endcase
        end
        for (int a = 0; a < 8; a++) rd(4'(a), "R6 final");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule